// File: doc/BRIEF.md
# I2C Write-Completion Acknowledge Poller

This block is a master-side sequencer for an I2C memory device whose internal write cycle keeps it deaf to the bus for a while after the stop that ends a byte load. Once that stop has gone out, a single `go` strobe starts the poller. Each attempt opens the bus with a start condition and sends the memory-array device address byte. If the device does not acknowledge, the poller closes the bus with a stop and tries again. When the device finally acknowledges, its write cycle is finished.

On success the `next_cmd` flag, sampled at `go`, decides what happens to the bus. If it is set, the poller leaves the bus open, with no stop, so that the following read or write command can continue at once. If it is clear, the poller sends a stop and releases the bus. The number of attempts has a ceiling set by a parameter; reaching it without an acknowledge raises a timeout and ends with a stop. Some devices also answer at a control/status address that would acknowledge even mid-write. Asking the poller to use that address is refused with a configuration error and touches no bus line.

The poller never drives SCL or SDA itself. It hands one command at a time to a bit-level engine over a request/acknowledge handshake.

Top module: `ack_poll_seq`

## Requirements
- R1: During and directly after synchronous reset, `cmd_req`, `done`, `timeout`, `cfg_err` and `bus_held` are low and `attempts` is 0.
- R2: After `go` with `poll_dev` different from `CSR_DEV`, the poller requests a start (`cmd_op`=0), then a byte send (`cmd_op`=1) with `cmd_byte`={`poll_dev`,`poll_rd`}, so device 57h gives AEh for a write and AFh for a read.
- R3: When the engine reports the address byte unacknowledged (`cmd_rx_ack`=0 with `cmd_ack`), and the limit is not reached, the next request is a stop (`cmd_op`=2) followed by a fresh start and address byte.
- R4: When the address byte is acknowledged and `next_cmd` was 1 at `go`, no stop is requested: `done` follows with `bus_held`=1 and `timeout`=0.
- R5: When the address byte is acknowledged and `next_cmd` was 0, one stop is requested, then `done` follows with `bus_held`=0.
- R6: `attempts` is cleared at an accepted `go` and counts the address bytes sent, so at `done` it equals the number of attempts made.
- R7: If `MAX_TRIES` address bytes in a row go unacknowledged, a final stop is requested and `done` comes with `timeout`=1 and `attempts`=`MAX_TRIES`. An acknowledge on the last allowed attempt still counts as success.
- R8: If `poll_dev` equals `CSR_DEV` (6Fh by default, the address behind bytes DEh/DFh), no command is requested, and `done` comes with `cfg_err`=1 and `attempts`=0.
- R9: `cmd_req` stays high, with `cmd_op` and `cmd_byte` unchanged, until the cycle the engine raises `cmd_ack`. Only one command is ever outstanding.
- R10: `done` is high for exactly one cycle per accepted `go`. `timeout`, `cfg_err` and `bus_held` hold their values until the next accepted `go`.
- R11: A `go` that arrives while a poll is in progress is ignored and changes neither the command sequence nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a poll (accepted only when idle) |
| poll_dev | input | 7 | 7-bit device address to poll |
| poll_rd | input | 1 | Direction bit placed in the address byte |
| next_cmd | input | 1 | A command follows: keep the bus open on success |
| cmd_req | output | 1 | Command request to the bit engine |
| cmd_op | output | 2 | 0 start, 1 send byte, 2 stop |
| cmd_byte | output | 8 | Byte to send for `cmd_op`=1 |
| cmd_ack | input | 1 | Engine has completed the requested command |
| cmd_rx_ack | input | 1 | Device acknowledged the byte (valid with `cmd_ack` on a send) |
| done | output | 1 | One-cycle finish pulse |
| attempts | output | CW | Address bytes sent in this poll |
| timeout | output | 1 | Attempt limit reached without acknowledge |
| cfg_err | output | 1 | Forbidden control/status address requested |
| bus_held | output | 1 | Success with the bus left open for the next command |

## Verification
Four properties are checked on every cycle by assertions: the request stays steady until it is acknowledged, `done` lasts one cycle, the count stays within the limit, and no byte carrying the control/status address is ever offered to the engine. Assertions also check that a timeout always reports the full attempt count and never comes with a held bus. Only the bench scenarios can show the full start/byte/stop order for a given number of device refusals. The same goes for the boundary between success on the last allowed attempt and a timeout, whether the bus is kept open or released, and that a stray `go` mid-poll leaves the sequence untouched.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

    // Command codes understood by the bit-level engine
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2,
        OP_IDLE  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_STOP_RETRY,
        S_STOP_END,
        S_FIN
    } poll_st_e;

    // Poll request captured at go
    typedef struct packed {
        logic [6:0] dev;
        logic       rd;
        logic       follow;
    } poll_req_t;

    // Outcome flags, held until the next go
    typedef struct packed {
        logic timeout;
        logic cfg_err;
        logic held;
    } poll_res_t;

    function automatic logic [7:0] addr_byte(input poll_req_t r);
        return {r.dev, r.rd};
    endfunction

endpackage

// File: rtl/apoll_try_ctr.sv
module apoll_try_ctr #(
    parameter int MAX_TRIES = 64,
    parameter int CW        = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          last
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != LIMIT)
            count <= count + 1'b1;
    end

    // Next address byte is the final one allowed
    assign last = (count == LIMIT - 1'b1);

    // R6
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT);

endmodule

// File: rtl/apoll_fsm.sv
module apoll_fsm
    import apoll_pkg::*;
#(
    parameter logic [6:0] CSR_DEV = 7'h6F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  poll_req_t  req_in,
    input  logic       cmd_ack,
    input  logic       cmd_rx_ack,
    input  logic       last_try,
    output logic       cmd_req,
    output bus_op_e    cmd_op,
    output logic [7:0] cmd_byte,
    output logic       ctr_clr,
    output logic       ctr_inc,
    output logic       done,
    output poll_res_t  result
);
    poll_st_e  st;
    poll_req_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cur    <= '0;
            result <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (go) begin
                    cur <= req_in;
                    if (req_in.dev == CSR_DEV) begin
                        result <= '{timeout: 1'b0, cfg_err: 1'b1, held: 1'b0};
                        st     <= S_FIN;
                    end else begin
                        result <= '0;
                        st     <= S_START;
                    end
                end
                S_START: if (cmd_ack) st <= S_ADDR;
                S_ADDR: if (cmd_ack) begin
                    if (cmd_rx_ack) begin
                        if (cur.follow) begin
                            result.held <= 1'b1;
                            st          <= S_FIN;
                        end else begin
                            st <= S_STOP_END;
                        end
                    end else if (last_try) begin
                        result.timeout <= 1'b1;
                        st             <= S_STOP_END;
                    end else begin
                        st <= S_STOP_RETRY;
                    end
                end
                S_STOP_RETRY: if (cmd_ack) st <= S_START;
                S_STOP_END:   if (cmd_ack) st <= S_FIN;
                S_FIN:        st <= S_IDLE;
                default:      st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_req  = 1'b1;
        cmd_byte = 8'h00;
        unique case (st)
            S_START:      cmd_op = OP_START;
            S_ADDR: begin
                cmd_op   = OP_BYTE;
                cmd_byte = addr_byte(cur);
            end
            S_STOP_RETRY,
            S_STOP_END:   cmd_op = OP_STOP;
            default: begin
                cmd_op  = OP_IDLE;
                cmd_req = 1'b0;
            end
        endcase
    end

    assign ctr_clr = (st == S_IDLE) && go;
    assign ctr_inc = (st == S_ADDR) && cmd_ack;
    assign done    = (st == S_FIN);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_byte)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    no_csr_probe_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_op == OP_BYTE) |-> (cmd_byte[7:1] != CSR_DEV));

    // R4
    held_excl_chk: assert property (@(posedge clk) disable iff (rst)
        result.held |-> !(result.timeout || result.cfg_err));

endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
    import apoll_pkg::*;
#(
    parameter int         MAX_TRIES = 64,
    parameter logic [6:0] CSR_DEV   = 7'h6F,
    localparam int        CW        = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [6:0]    poll_dev,
    input  logic          poll_rd,
    input  logic          next_cmd,
    output logic          cmd_req,
    output logic [1:0]    cmd_op,
    output logic [7:0]    cmd_byte,
    input  logic          cmd_ack,
    input  logic          cmd_rx_ack,
    output logic          done,
    output logic [CW-1:0] attempts,
    output logic          timeout,
    output logic          cfg_err,
    output logic          bus_held
);
    poll_req_t req_in;
    poll_res_t res;
    bus_op_e   op;
    logic      ctr_clr, ctr_inc, last_try;

    assign req_in = '{dev: poll_dev, rd: poll_rd, follow: next_cmd};

    apoll_fsm #(.CSR_DEV(CSR_DEV)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .req_in    (req_in),
        .cmd_ack   (cmd_ack),
        .cmd_rx_ack(cmd_rx_ack),
        .last_try  (last_try),
        .cmd_req   (cmd_req),
        .cmd_op    (op),
        .cmd_byte  (cmd_byte),
        .ctr_clr   (ctr_clr),
        .ctr_inc   (ctr_inc),
        .done      (done),
        .result    (res)
    );

    apoll_try_ctr #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctr_clr),
        .inc  (ctr_inc),
        .count(attempts),
        .last (last_try)
    );

    assign cmd_op   = op;
    assign timeout  = res.timeout;
    assign cfg_err  = res.cfg_err;
    assign bus_held = res.held;

    // R7
    timeout_count_chk: assert property (@(posedge clk) disable iff (rst)
        (done && timeout) |-> (attempts == CW'(MAX_TRIES)));

    // R8
    cfg_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_err) |-> (attempts == '0));

endmodule

// File: tb/ack_poll_seq_tb.sv
module ack_poll_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXT       = 5;
    localparam int CW         = $clog2(MAXT + 1);

    logic          clk = 0;
    logic          rst = 1;
    logic          go = 0;
    logic [6:0]    poll_dev = 7'h57;
    logic          poll_rd = 0;
    logic          next_cmd = 0;
    logic          cmd_req;
    logic [1:0]    cmd_op;
    logic [7:0]    cmd_byte;
    logic          cmd_ack = 0;
    logic          cmd_rx_ack = 0;
    logic          done;
    logic [CW-1:0] attempts;
    logic          timeout, cfg_err, bus_held;

    ack_poll_seq #(.MAX_TRIES(MAXT)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [1:0] op; logic [7:0] b; } op_t;
    typedef struct { int att; logic to; logic ce; logic hd; } res_t;

    op_t  exp_ops[$];
    res_t exp_res[$];
    int   n_chk = 0, n_bad = 0;
    int   dev_nacks = 0;
    int   cyc = 0;

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Engine model: compares every request against the expected queue
    initial begin
        int nreq = 0;
        forever begin
            @(negedge clk);
            cmd_ack = 0;
            if (cmd_req && !rst) begin
                op_t e;
                logic [1:0] o0;
                logic [7:0] b0;
                o0 = cmd_op; b0 = cmd_byte;
                if (exp_ops.size() == 0) begin
                    chk(0, $sformatf("R2 R3 R4 R5 unexpected cmd op=%0d byte=%02h expected none", o0, b0));
                end else begin
                    e = exp_ops.pop_front();
                    chk(o0 == e.op && (o0 != 2'd1 || b0 == e.b),
                        $sformatf("R2 R3 R5 cmd op=%0d byte=%02h expected op=%0d byte=%02h", o0, b0, e.op, e.b));
                end
                for (int k = 0; k < (nreq % 3); k++) begin
                    @(negedge clk);
                    chk(cmd_req && cmd_op == o0 && cmd_byte == b0,
                        $sformatf("R9 req=%0b op=%0d byte=%02h expected held op=%0d byte=%02h", cmd_req, cmd_op, cmd_byte, o0, b0));
                end
                nreq++;
                if (o0 == 2'd1) begin
                    if (dev_nacks > 0) begin cmd_rx_ack = 0; dev_nacks--; end
                    else cmd_rx_ack = 1;
                end else cmd_rx_ack = 0;
                cmd_ack = 1;
            end
        end
    end

    // Monitor: result scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done && !rst) begin
                res_t e;
                if (exp_res.size() == 0) begin
                    chk(0, "R10 unexpected done, expected none");
                end else begin
                    e = exp_res.pop_front();
                    chk(int'(attempts) == e.att, $sformatf("R6 R7 attempts=%0d expected %0d", attempts, e.att));
                    chk(timeout == e.to && cfg_err == e.ce && bus_held == e.hd,
                        $sformatf("R4 R7 R8 flags to/ce/hd=%0b%0b%0b expected %0b%0b%0b",
                                  timeout, cfg_err, bus_held, e.to, e.ce, e.hd));
                end
                @(negedge clk);
                chk(!done, $sformatf("R10 done=%0b expected 0 one cycle later", done));
                chk(exp_ops.size() == 0, $sformatf("R3 R5 commands left=%0d expected 0", exp_ops.size()));
                chk(timeout == e.to && cfg_err == e.ce && bus_held == e.hd,
                    $sformatf("R10 flags not held to/ce/hd=%0b%0b%0b", timeout, cfg_err, bus_held));
            end
        end
    end

    task automatic run(input int nacks, input bit follow, input bit rd,
                       input logic [6:0] dev, input bit stray_go);
        logic [7:0] ab;
        res_t r;
        ab = {dev, rd};
        if (dev == 7'h6F) begin
            r = '{att: 0, to: 0, ce: 1, hd: 0};
        end else begin
            int full = (nacks < MAXT) ? nacks : MAXT;
            for (int i = 0; i < full; i++) begin
                exp_ops.push_back('{op: 2'd0, b: 8'h00});
                exp_ops.push_back('{op: 2'd1, b: ab});
                exp_ops.push_back('{op: 2'd2, b: 8'h00});
            end
            if (nacks < MAXT) begin
                exp_ops.push_back('{op: 2'd0, b: 8'h00});
                exp_ops.push_back('{op: 2'd1, b: ab});
                if (!follow) exp_ops.push_back('{op: 2'd2, b: 8'h00});
                r = '{att: nacks + 1, to: 0, ce: 0, hd: follow};
            end else begin
                r = '{att: MAXT, to: 1, ce: 0, hd: 0};
            end
        end
        exp_res.push_back(r);
        dev_nacks = nacks;
        @(negedge clk);
        poll_dev = dev; poll_rd = rd; next_cmd = follow; go = 1;
        @(negedge clk);
        go = 0;
        if (stray_go) begin
            repeat (3) @(negedge clk);
            poll_dev = 7'h6F; next_cmd = ~follow; go = 1;   // R11 stray go mid-poll
            @(negedge clk);
            go = 0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(0, "watchdog expired expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!cmd_req && !done && attempts == 0 && !timeout && !cfg_err && !bus_held,
            $sformatf("R1 reset req=%0b done=%0b att=%0d expected all 0", cmd_req, done, attempts));
        rst = 0;
        @(negedge clk);
        chk(!cmd_req && !done && attempts == 0,
            $sformatf("R1 after reset req=%0b done=%0b att=%0d expected 0", cmd_req, done, attempts));
        run(0, 0, 0, 7'h57, 0);        // R2 R5 AEh, immediate ack
        run(2, 1, 1, 7'h57, 0);        // R3 R4 AFh, two refusals, bus kept
        run(MAXT-1, 0, 0, 7'h57, 0);   // R7 ack on last allowed try
        run(MAXT, 0, 1, 7'h57, 0);     // R7 timeout
        run(0, 0, 0, 7'h6F, 0);        // R8 DEh requested
        run(0, 1, 1, 7'h6F, 0);        // R8 DFh requested
        run(1, 0, 0, 7'h57, 1);        // R11 stray go ignored
        run(0, 1, 0, 7'h57, 0);        // R4 R6 bus kept after one try
        run(3, 0, 1, 7'h57, 0);        // R6 count restarts
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule